// File: doc/BRIEF.md
# Serial Line Break and Idle Watcher

This block runs next to an asynchronous serial frame receiver and watches the same oversampled line, one sample per clock. It works out how long one frame lasts in samples from the frame geometry on its inputs: bit width in samples, data bit count, parity on or off, and the stop length in half bits. It uses that length as the threshold for two conditions. A break is a line held in its active (low) state for at least one frame time. An idle period is a line held in its inactive (high) state for one frame time, counted from a moving start point.

Every sample is numbered by a free-running counter that the block exports. The receiver reports its frame events in that numbering: a normal frame completion together with the sample number at which the frame began, and an abort when a start bit fails its check. Each detection gives a one-cycle pulse together with the first and last sample numbers of the condition. A polarity setting is applied to the line before both detectors, so break always means the active state.

Top module: `uart_line_watch`

## Requirements
- R1: `frame_len` equals ceil(((1 + data_bits + parity_en) × 2 + stop_halves) × bit_width / 2), where `stop_halves` gives the stop length in half bits (0 to 4, meaning 0 to 2 stop bits).
- R2: When the level has been low without a break from sample S to sample N and N − S ≥ `frame_len`, `brk_pulse` is high in the cycle after sample N is taken, with `brk_start` = S and `brk_end` = N.
- R3: A low period gives at most one break report; a return to high re-arms detection, and the next fall starts a new break measurement.
- R4: A low period shorter than `frame_len` samples gives no break report.
- R5: With the level high at sample N, not rising at N, and N ≥ I + `frame_len` for the current idle start I, `idle_pulse` is high in the cycle after sample N, with `idle_start` = I and `idle_end` = N.
- R6: After an idle report ending at sample N, the idle start becomes N, so a steady high line repeats the report every `frame_len` samples.
- R7: A `frame_done` pulse taken with sample N sets the idle start to `frame_start` + `frame_len` and suppresses an idle report at N.
- R8: A `frame_abort` pulse taken with sample N sets the idle start to N + ceil(`bit_width` / 2) and suppresses an idle report at N.
- R9: A fall to low stops idle measurement; the next rise to high sets the idle start to the sample of that rise.
- R10: With `invert` = 1 the line value is complemented before both detectors, so a line input held at 1 is treated as the active level.
- R11: `brk_pulse` and `idle_pulse` each last one cycle and are never high together.
- R12: During reset `sample_cnt`, `brk_pulse` and `idle_pulse` are 0; sample 0 is the first sample taken after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Serial line sample |
| invert | input | 1 | Complement the line before detection |
| bit_width | input | BW_W | Samples per bit |
| data_bits | input | 4 | Data bits per frame |
| parity_en | input | 1 | Frame carries a parity bit |
| stop_halves | input | 3 | Stop length in half bits |
| frame_done | input | 1 | Receiver finished a frame normally |
| frame_start | input | CNT_W | Sample number at which that frame began |
| frame_abort | input | 1 | Receiver dropped a frame on a bad start bit |
| sample_cnt | output | CNT_W | Number of the sample taken at the next edge |
| frame_len | output | BW_W+5 | Frame length in samples |
| brk_pulse | output | 1 | Break detected |
| brk_start | output | CNT_W | First sample of the break |
| brk_end | output | CNT_W | Sample at which the break was reported |
| idle_pulse | output | 1 | Idle period detected |
| idle_start | output | CNT_W | First sample of the idle period |
| idle_end | output | CNT_W | Sample at which the idle period was reported |

## Verification
The assertions check on every cycle that the two pulses never overlap and last one cycle, that a break report comes only from a low line and an idle report only from a high one, and that each reported span is at least one frame length long. Where the idle measurement restarts after a normal frame, after an abort, after a rise, or after a previous report, and that a short low or a continuing low gives no second break, can only be shown by the bench's timed scenarios, which predict the exact sample of each report. The bench also checks the frame length formula over a table of geometries and the effect of the polarity setting.

// File: rtl/uart_line_watch.sv
module uart_line_watch #(
  parameter int CNT_W = 32,
  parameter int BW_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             invert,
  input  logic [BW_W-1:0]  bit_width,
  input  logic [3:0]       data_bits,
  input  logic             parity_en,
  input  logic [2:0]       stop_halves,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] frame_start,
  input  logic             frame_abort,
  output logic [CNT_W-1:0] sample_cnt,
  output logic [BW_W+4:0]  frame_len,
  output logic             brk_pulse,
  output logic [CNT_W-1:0] brk_start,
  output logic [CNT_W-1:0] brk_end,
  output logic             idle_pulse,
  output logic [CNT_W-1:0] idle_start,
  output logic [CNT_W-1:0] idle_end
);
  localparam int HALF_W = 5;
  localparam int LEN_W  = BW_W + HALF_W;

  logic [HALF_W-1:0] halves;
  logic [LEN_W-1:0]  prod;
  logic [CNT_W-1:0]  flen, half_bit, low_from, idle_from;
  logic              lvl, prev, armed, rise, fall, brk_hit, idle_hit;

  assign halves    = HALF_W'(2) + HALF_W'({data_bits, 1'b0}) + HALF_W'({parity_en, 1'b0})
                   + HALF_W'(stop_halves);
  assign prod      = LEN_W'(halves) * LEN_W'(bit_width);
  assign frame_len = LEN_W'((prod + LEN_W'(1)) >> 1);
  assign flen      = CNT_W'(frame_len);
  assign half_bit  = CNT_W'(({1'b0, bit_width} + 1'b1) >> 1);

  assign lvl  = line_in ^ invert;
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  assign brk_hit  = ~lvl & ~prev & armed & ((sample_cnt - low_from) >= flen);
  assign idle_hit = lvl & ~rise & ~frame_done & ~frame_abort
                  & ({1'b0, sample_cnt} >= ({1'b0, idle_from} + {1'b0, flen}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_cnt <= '0;
      prev       <= 1'b1;
      armed      <= 1'b0;
      low_from   <= '0;
      idle_from  <= '0;
      brk_pulse  <= 1'b0;
      idle_pulse <= 1'b0;
      brk_start  <= '0;
      brk_end    <= '0;
      idle_start <= '0;
      idle_end   <= '0;
    end else begin
      sample_cnt <= sample_cnt + 1'b1;
      prev       <= lvl;
      brk_pulse  <= brk_hit;
      idle_pulse <= idle_hit;

      if (fall) begin
        low_from <= sample_cnt;
        armed    <= 1'b1;
      end else if (lvl || brk_hit) begin
        armed <= 1'b0;
      end
      if (brk_hit) begin
        brk_start <= low_from;
        brk_end   <= sample_cnt;
      end

      if (frame_done) begin
        idle_from <= frame_start + flen;
      end else if (frame_abort) begin
        idle_from <= sample_cnt + half_bit;
      end else if (idle_hit) begin
        idle_from  <= sample_cnt;
        idle_start <= idle_from;
        idle_end   <= sample_cnt;
      end else if (rise) begin
        idle_from <= sample_cnt;
      end
    end
  end

  assert_one_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_pulse && idle_pulse));
  assert_brk_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);
  assert_idle_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !idle_pulse);
  assert_brk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> (brk_pulse && !prev));
  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> (idle_pulse && prev));
  assert_brk_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> ((brk_end - brk_start) >= $past(flen)));
  assert_idle_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> ((idle_end - idle_start) >= $past(flen)));
  assert_idle_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> (idle_from == idle_end));
endmodule

// File: tb/tb_uart_line_watch.sv
module tb_uart_line_watch;
  localparam int CNT_W = 32;
  localparam int BW_W  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1, invert = 1'b0, parity_en = 1'b0;
  logic [BW_W-1:0] bit_width = 12'd4;
  logic [3:0] data_bits = 4'd8;
  logic [2:0] stop_halves = 3'd2;
  logic frame_done = 1'b0, frame_abort = 1'b0;
  logic [CNT_W-1:0] frame_start = '0;
  logic [CNT_W-1:0] sample_cnt, brk_start, brk_end, idle_start, idle_end;
  logic [BW_W+4:0] frame_len;
  logic brk_pulse, idle_pulse;

  uart_line_watch #(.CNT_W(CNT_W), .BW_W(BW_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(invert),
    .bit_width(bit_width), .data_bits(data_bits), .parity_en(parity_en),
    .stop_halves(stop_halves), .frame_done(frame_done), .frame_start(frame_start),
    .frame_abort(frame_abort), .sample_cnt(sample_cnt), .frame_len(frame_len),
    .brk_pulse(brk_pulse), .brk_start(brk_start), .brk_end(brk_end),
    .idle_pulse(idle_pulse), .idle_start(idle_start), .idle_end(idle_end));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, n = 0;
  bit done = 1'b0;

  localparam int NV = 6;
  localparam int V_BW [NV] = '{4, 5, 3, 16, 7, 1};
  localparam int V_DB [NV] = '{8, 8, 7, 9, 5, 5};
  localparam int V_PE [NV] = '{0, 0, 1, 1, 0, 0};
  localparam int V_SH [NV] = '{2, 1, 3, 4, 0, 1};
  localparam int V_LN [NV] = '{40, 48, 32, 208, 42, 7};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    n++;
    @(negedge clk);
  endtask

  task automatic expect_pulse(input bit is_brk, input int limit, input int e_idx,
                              input int e_start, input string req);
    int got = -1;
    for (int i = 0; i < limit; i++) begin
      step();
      if (is_brk ? brk_pulse : idle_pulse) begin
        got = n - 1;
        break;
      end
    end
    chk(got == e_idx, req, got, e_idx);
    chk(int'(is_brk ? brk_start : idle_start) == e_start, req,
        int'(is_brk ? brk_start : idle_start), e_start);
    chk(int'(is_brk ? brk_end : idle_end) == e_idx, req,
        int'(is_brk ? brk_end : idle_end), e_idx);
    step();
    chk(!(is_brk ? brk_pulse : idle_pulse), "R11", 1, 0);
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (brk_pulse || idle_pulse) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, fs, a0;
    // R1: frame length table, walked while reset holds
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      bit_width = BW_W'(V_BW[v]);
      data_bits = 4'(V_DB[v]);
      parity_en = 1'(V_PE[v]);
      stop_halves = 3'(V_SH[v]);
      #1;
      chk(int'(frame_len) == V_LN[v], "R1", int'(frame_len), V_LN[v]);
    end
    bit_width = 12'd4; data_bits = 4'd8; parity_en = 1'b0; stop_halves = 3'd2;
    @(negedge clk);
    // R12: reset state
    chk(sample_cnt == 0, "R12", int'(sample_cnt), 0);
    chk(!brk_pulse && !idle_pulse, "R12", int'(brk_pulse | idle_pulse), 0);
    rst_n = 1'b1;
    n = 0;

    // R5, R6: steady high from reset reports idle each frame length
    expect_pulse(1'b0, 100, 40, 0, "R5");
    expect_pulse(1'b0, 100, 80, 40, "R6");

    // R2: break after a full frame of low
    line_in = 1'b0; k = n;
    expect_pulse(1'b1, 100, k + 40, k, "R2");
    // R3: continuing low gives no second report
    quiet(60, "R3");
    line_in = 1'b1;
    quiet(5, "R3");
    line_in = 1'b0; k = n;
    expect_pulse(1'b1, 100, k + 40, k, "R3");

    // R9, R4: rise restarts idle, a short low neither breaks nor lets idle run
    line_in = 1'b1;
    quiet(20, "R9");
    line_in = 1'b0;
    quiet(30, "R4");
    line_in = 1'b1; k = n;
    expect_pulse(1'b0, 100, k + 40, k, "R9");

    // R7: normal frame end moves idle start to frame start plus frame length
    fs = n - 30;
    frame_start = CNT_W'(fs); frame_done = 1'b1; k = n;
    step();
    frame_done = 1'b0;
    expect_pulse(1'b0, 100, k + 50, k + 10, "R7");

    // R8: abort moves idle start to half a bit after the abort sample
    a0 = n;
    frame_abort = 1'b1;
    step();
    frame_abort = 1'b0;
    expect_pulse(1'b0, 100, a0 + 42, a0 + 2, "R8");

    // R10: inversion makes a line held at 1 the active level
    invert = 1'b1; k = n;
    expect_pulse(1'b1, 100, k + 40, k, "R10");
    line_in = 1'b0;
    quiet(10, "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule